// File: doc/BRIEF.md
# Cascadable Arithmetic/Logic Slice Pair

This block is a 4-bit arithmetic/logic slice, built so that slices can be chained into wider words, together with an 8-bit top that joins two of them and registers the results. A mode input picks between arithmetic and bitwise logic. A 4-bit select then picks the operation. In arithmetic mode, select `1001` adds the operands and select `0110` subtracts B from A. Every other arithmetic select passes A through with the carry added. In logic mode, the select is read as the truth table of a two-input function, and that function is applied to each bit.

Carry-in and carry-out are active low. The carry-out of the low slice drives the carry-in of the high slice, and both slices share one select and one mode. Each slice reports its group generate and group propagate, also active low, so that an external look-ahead unit could use them. The top also reports whether the two whole operands are equal.

All outputs are registered once in the top. A result therefore appears one clock after its operands are presented.

Top module: `alu_cascade`

## Requirements
- R1: While rst_ni is low, f_o is 0, cn_no is 1, all bits of g_no and p_no are 1, and eq_o is 0.
- R2: Every output reflects the inputs sampled at the previous rising clock edge, which is one cycle of latency.
- R3: With mode_i=0 and sel_i=4'b1001, f_o equals (a_i + b_i + c) mod 256, where c is 1 when cn_ni is 0 and 0 when cn_ni is 1.
- R4: With mode_i=0 and sel_i=4'b0110, f_o equals (a_i + ~b_i + c) mod 256. With cn_ni=0 this is the exact two's-complement difference a_i − b_i.
- R5: In arithmetic mode, cn_no is 0 exactly when the 8-bit sum carries out. In a subtraction with cn_ni=0, cn_no is therefore 0 when a_i ≥ b_i and 1 when the result is negative.
- R6: With mode_i=0 and any select other than 1001 or 0110, f_o equals (a_i + c) mod 256, with c defined as in R3.
- R7: A carry out of bits 3:0 reaches bits 7:4, so 0x0F + 0x01 with cn_ni=1 gives 0x10.
- R8: With mode_i=1, bit i of f_o equals sel_i[2*a_i[i] + b_i[i]]. For example, 1000 is AND, 1110 is OR, 0110 is XOR and 1100 passes A.
- R9: With mode_i=1, cn_no is 1, all bits of g_no and p_no are 1, and cn_ni has no effect on f_o.
- R10: In arithmetic mode, g_no[j] is the inverted group generate of slice j, where bit k generates on a&y and propagates on a|y, and y is the operand chosen by the select. p_no[j] is the inverted AND of that slice's propagate bits.
- R11: eq_o is 1 exactly when a_i equals b_i, in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | 8 | Operand A |
| b_i | input | 8 | Operand B |
| sel_i | input | 4 | Function select |
| mode_i | input | 1 | 0 = arithmetic, 1 = logic |
| cn_ni | input | 1 | Carry-in, active low |
| f_o | output | 8 | Result |
| cn_no | output | 1 | Carry-out of the high slice, active low |
| g_no | output | 2 | Group generate of each slice, active low |
| p_no | output | 2 | Group propagate of each slice, active low |
| eq_o | output | 1 | Operands equal |

## Verification
Fixed sums and differences are applied first: 97+29 and 97−29, a difference that goes negative, and 0x0F+0x01. Together they separate a correct carry from the low slice into the high one from a broken one, and they separate the two meanings of the carry-out sign. Logic mode is driven with AND, OR, XOR, pass-A and all-ones selects, and each is applied with both carry-in values, so that a wrong truth-table index or a carry that leaks into the result shows up. A run of pseudo-random operands, selects and modes is then compared every cycle against a behavioural integer model. That run reaches the generate/propagate patterns, the pass-through codes and the equal-operand cases.

// File: rtl/alu_cascade_pkg.sv
package alu_cascade_pkg;
  localparam int unsigned SEL_W = 4;
  typedef logic [SEL_W-1:0] sel_t;
  localparam sel_t SEL_ADD = 4'b1001;
  localparam sel_t SEL_SUB = 4'b0110;

  typedef enum logic {
    MODE_ARITH = 1'b0,
    MODE_LOGIC = 1'b1
  } mode_e;
endpackage

// File: rtl/alu_slice_arith.sv
module alu_slice_arith
  import alu_cascade_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  sel_t         sel_i,
  input  logic         cn_ni,
  output logic [W-1:0] sum_o,
  output logic         co_o,
  output logic         grp_g_o,
  output logic         grp_p_o
);
  logic [W-1:0] y;
  logic [W-1:0] gen, prop;
  logic [W:0]   c;
  logic [W-1:0] g_acc, p_acc;

  always_comb begin
    unique case (sel_i)
      SEL_ADD: y = b_i;
      SEL_SUB: y = ~b_i;
      default: y = '0;
    endcase
  end

  assign c[0] = ~cn_ni;

  for (genvar k = 0; k < W; k++) begin : g_bit
    assign gen[k]   = a_i[k] & y[k];
    assign prop[k]  = a_i[k] | y[k];
    assign c[k+1]   = gen[k] | (prop[k] & c[k]);
    assign sum_o[k] = a_i[k] ^ y[k] ^ c[k];
    if (k == 0) begin : g_first
      assign g_acc[k] = gen[k];
      assign p_acc[k] = prop[k];
    end else begin : g_rest
      assign g_acc[k] = gen[k] | (prop[k] & g_acc[k-1]);
      assign p_acc[k] = prop[k] & p_acc[k-1];
    end
  end

  assign co_o    = c[W];
  assign grp_g_o = g_acc[W-1];
  assign grp_p_o = p_acc[W-1];
endmodule

// File: rtl/alu_slice_logic.sv
module alu_slice_logic
  import alu_cascade_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  sel_t         sel_i,
  output logic [W-1:0] f_o
);
  // select is the truth table, indexed by {a,b}
  for (genvar k = 0; k < W; k++) begin : g_bit
    assign f_o[k] = sel_i[{a_i[k], b_i[k]}];
  end
endmodule

// File: rtl/alu_slice.sv
module alu_slice
  import alu_cascade_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  sel_t         sel_i,
  input  logic         mode_i,
  input  logic         cn_ni,
  output logic [W-1:0] f_o,
  output logic         cn_no,
  output logic         g_no,
  output logic         p_no,
  output logic         eq_o
);
  logic [W-1:0] arith_f, logic_f;
  logic         co, grp_g, grp_p;
  logic         is_logic;

  assign is_logic = (mode_i == MODE_LOGIC);

  alu_slice_arith #(.W(W)) u_arith (
    .a_i     (a_i),
    .b_i     (b_i),
    .sel_i   (sel_i),
    .cn_ni   (cn_ni),
    .sum_o   (arith_f),
    .co_o    (co),
    .grp_g_o (grp_g),
    .grp_p_o (grp_p)
  );

  alu_slice_logic #(.W(W)) u_logic (
    .a_i   (a_i),
    .b_i   (b_i),
    .sel_i (sel_i),
    .f_o   (logic_f)
  );

  assign f_o   = is_logic ? logic_f : arith_f;
  assign cn_no = is_logic ? 1'b1 : ~co;
  assign g_no  = is_logic ? 1'b1 : ~grp_g;
  assign p_no  = is_logic ? 1'b1 : ~grp_p;
  assign eq_o  = (a_i == b_i);
endmodule

// File: rtl/alu_cascade.sv
module alu_cascade
  import alu_cascade_pkg::*;
#(
  parameter int unsigned SLICE_W  = 4,
  parameter int unsigned N_SLICES = 2,
  localparam int unsigned DATA_W  = SLICE_W * N_SLICES
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [DATA_W-1:0]   a_i,
  input  logic [DATA_W-1:0]   b_i,
  input  logic [SEL_W-1:0]    sel_i,
  input  logic                mode_i,
  input  logic                cn_ni,
  output logic [DATA_W-1:0]   f_o,
  output logic                cn_no,
  output logic [N_SLICES-1:0] g_no,
  output logic [N_SLICES-1:0] p_no,
  output logic                eq_o
);
  logic [N_SLICES:0]   chain_n;
  logic [DATA_W-1:0]   f_d;
  logic [N_SLICES-1:0] g_d, p_d, eq_d;

  assign chain_n[0] = cn_ni;

  for (genvar s = 0; s < N_SLICES; s++) begin : g_slice
    alu_slice #(.W(SLICE_W)) u_slice (
      .a_i    (a_i[s*SLICE_W +: SLICE_W]),
      .b_i    (b_i[s*SLICE_W +: SLICE_W]),
      .sel_i  (sel_i),
      .mode_i (mode_i),
      .cn_ni  (chain_n[s]),
      .f_o    (f_d[s*SLICE_W +: SLICE_W]),
      .cn_no  (chain_n[s+1]),
      .g_no   (g_d[s]),
      .p_no   (p_d[s]),
      .eq_o   (eq_d[s])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      f_o   <= '0;
      cn_no <= 1'b1;
      g_no  <= '1;
      p_no  <= '1;
      eq_o  <= 1'b0;
    end else begin
      f_o   <= f_d;
      cn_no <= chain_n[N_SLICES];
      g_no  <= g_d;
      p_no  <= p_d;
      eq_o  <= &eq_d;
    end
  end
endmodule

// File: rtl/alu_cascade_chk.sv
module alu_cascade_chk #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned N_SLICES = 2
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [DATA_W-1:0]   a_i,
  input logic [DATA_W-1:0]   b_i,
  input logic [3:0]          sel_i,
  input logic                mode_i,
  input logic                cn_ni,
  input logic [DATA_W-1:0]   f_o,
  input logic                cn_no,
  input logic [N_SLICES-1:0] g_no,
  input logic [N_SLICES-1:0] p_no,
  input logic                eq_o
);
  p_reset_r1: assert property (@(posedge clk_i)
    !rst_ni |=> (!rst_ni |-> (f_o == '0 && cn_no && &g_no && &p_no && !eq_o)));

  p_add_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$past(mode_i) && $past(sel_i) == 4'b1001)
    |-> f_o == DATA_W'($past(a_i) + $past(b_i) + DATA_W'(!$past(cn_ni))));

  p_sub_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$past(mode_i) && $past(sel_i) == 4'b0110 && !$past(cn_ni))
    |-> f_o == DATA_W'($past(a_i) - $past(b_i)));

  p_sub_sign_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$past(mode_i) && $past(sel_i) == 4'b0110 && !$past(cn_ni))
    |-> cn_no == ($past(a_i) < $past(b_i)));

  p_logic_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(mode_i)) |-> (cn_no && &g_no && &p_no));

  p_equal_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> eq_o == ($past(a_i) == $past(b_i)));
endmodule

bind alu_cascade alu_cascade_chk #(.DATA_W(DATA_W), .N_SLICES(N_SLICES)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .a_i    (a_i),
  .b_i    (b_i),
  .sel_i  (sel_i),
  .mode_i (mode_i),
  .cn_ni  (cn_ni),
  .f_o    (f_o),
  .cn_no  (cn_no),
  .g_no   (g_no),
  .p_no   (p_no),
  .eq_o   (eq_o)
);

// File: tb/alu_cascade_tb.sv
module alu_cascade_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] a_i = '0, b_i = '0;
  logic [3:0] sel_i = '0;
  logic       mode_i = 1'b0, cn_ni = 1'b1;
  logic [7:0] f_o;
  logic       cn_no, eq_o;
  logic [1:0] g_no, p_no;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  alu_cascade u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .a_i(a_i), .b_i(b_i), .sel_i(sel_i),
    .mode_i(mode_i), .cn_ni(cn_ni), .f_o(f_o), .cn_no(cn_no), .g_no(g_no),
    .p_no(p_no), .eq_o(eq_o)
  );

  // behavioural reference
  function automatic void model(input int a, input int b, input int sel, input int md,
                                input int cn, output int f, output int co,
                                output int g, output int p, output int eq);
    int y, cin, s;
    eq = (a == b) ? 1 : 0;
    if (md == 1) begin
      f = 0;
      for (int i = 0; i < 8; i++) begin
        int idx;
        idx = ((a >> i) & 1) * 2 + ((b >> i) & 1);
        f += ((sel >> idx) & 1) << i;
      end
      co = 1; g = 3; p = 3;
    end else begin
      y   = (sel == 9) ? b : (sel == 6) ? (255 - b) : 0;
      cin = (cn == 0) ? 1 : 0;
      s   = a + y + cin;
      f   = s % 256;
      co  = (s > 255) ? 0 : 1;
      g = 0; p = 0;
      for (int j = 0; j < 2; j++) begin
        int a4, y4;
        a4 = (a >> (4 * j)) & 15;
        y4 = (y >> (4 * j)) & 15;
        if (!((a4 + y4) > 15)) g += 1 << j;
        if (!((a4 | y4) == 15)) p += 1 << j;
      end
    end
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive at negedge, check one cycle later (R2)
  task automatic apply(input int a, input int b, input int sel, input int md,
                       input int cn, input string tag);
    int f, co, g, p, eq;
    @(negedge clk_i);
    a_i = 8'(a); b_i = 8'(b); sel_i = 4'(sel); mode_i = md[0]; cn_ni = cn[0];
    model(a, b, sel, md, cn, f, co, g, p, eq);
    @(posedge clk_i);
    #1;
    chk({tag, " R2 f"}, int'(f_o), f);
    chk({tag, " R5 cn_no"}, int'(cn_no), co);
    chk({tag, " R10 g_no"}, int'(g_no), g);
    chk({tag, " R10 p_no"}, int'(p_no), p);
    chk({tag, " R11 eq"}, int'(eq_o), eq);
  endtask

  initial begin
    #200000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int s;
    repeat (3) @(posedge clk_i);
    #1;
    // R1
    chk("R1 f", int'(f_o), 0);
    chk("R1 cn_no", int'(cn_no), 1);
    chk("R1 g_no", int'(g_no), 3);
    chk("R1 p_no", int'(p_no), 3);
    chk("R1 eq", int'(eq_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    apply(97, 29, 9, 0, 1, "R3 add 97+29");
    chk("R3 sum 126", int'(f_o), 126);
    apply(97, 29, 9, 0, 0, "R3 add with carry");
    chk("R3 sum 127", int'(f_o), 127);
    apply(97, 29, 6, 0, 0, "R4 sub 97-29");
    chk("R4 diff 68", int'(f_o), 68);
    chk("R5 nonneg", int'(cn_no), 0);
    apply(29, 97, 6, 0, 0, "R4 sub neg");
    chk("R4 diff 188", int'(f_o), 188);
    chk("R5 negative", int'(cn_no), 1);
    apply(15, 1, 9, 0, 1, "R7 cross");
    chk("R7 0x10", int'(f_o), 16);
    apply(200, 100, 9, 0, 1, "R5 wrap");
    chk("R5 carry out", int'(cn_no), 0);
    apply(255, 3, 0, 0, 0, "R6 pass wrap");
    chk("R6 A+1", int'(f_o), 0);
    apply(77, 3, 15, 0, 1, "R6 pass");
    chk("R6 A", int'(f_o), 77);
    apply(8'hC3, 8'hC3, 5, 0, 1, "R11 equal");
    chk("R11 eq hi", int'(eq_o), 1);
    for (int cn = 0; cn < 2; cn++) begin
      apply(8'hCA, 8'hAC, 8, 1, cn, "R8 and");
      chk("R8 and", int'(f_o), 8'h88);
      apply(8'hCA, 8'hAC, 14, 1, cn, "R8 or");
      chk("R8 or", int'(f_o), 8'hEE);
      apply(8'hCA, 8'hAC, 6, 1, cn, "R8 xor");
      chk("R8 xor", int'(f_o), 8'h66);
      apply(8'hCA, 8'hAC, 12, 1, cn, "R9 passA");
      chk("R9 passA no carry effect", int'(f_o), 8'hCA);
      apply(8'hFF, 8'hFF, 15, 1, cn, "R9 ones");
      chk("R9 cn_no", int'(cn_no), 1);
    end
    s = 12345;
    for (int i = 0; i < 400; i++) begin
      int a, b, sel, md, cn;
      s = (s * 1103515245 + 12345) & 32'h7fffffff;
      a = s & 255; b = (s >> 8) & 255; sel = (s >> 16) & 15;
      md = (s >> 20) & 1; cn = (s >> 21) & 1;
      if (((s >> 22) & 3) == 0) sel = 9;
      if (((s >> 22) & 3) == 1) sel = 6;
      if (((s >> 24) & 15) == 0) b = a;
      apply(a, b, sel, md, cn, "rand R3 R4 R6 R8");
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule